// File: doc/BRIEF.md
# Strobe-Aligned Codeword Receiver

This block turns a parallel codeword link, carried on a 32-bit general-purpose input bus, into trigger events for a waveform sequencer. The sender toggles one bus line continuously. Every transition of that line, rising or falling, opens one codeword slot. A second line marks the slots that carry a codeword. A masked and right-shifted part of the bus gives the codeword index. The link's highest slot rate is 50 MHz, and slower links run at an integer fraction of that rate.

The receiver oversamples the whole bus with its own fast clock through a synchronizer chain. It finds strobe transitions by comparing consecutive synchronized samples. A programmable number of fast cycles after each transition, it samples the valid line and the codeword field, so the sample falls clear of the few nanoseconds of skew between strobe and data. A small register file, written through a plain write port, selects the strobe pin, the valid pin, the mask, the shift, the sampling delay and a minimum strobe spacing. Two strobe transitions that arrive closer together than that spacing raise an error pulse.

Events leave on a valid/ready stream. An event stays on the output with a stable index until the consumer takes it with ready high. The output holds only one event. If a newer codeword is captured while an event is still waiting, the newer one replaces it. A consumer that keeps ready high sees each event for exactly one cycle.

Top module: `cw_strobe_rx`

## Requirements
- R1: After reset, evt_valid and err_spacing are low, and no strobe transition is recognised until SYNC_STAGES+1 cycles after reset is released. Register reset values: strobe pin 31, valid pin 30, mask 0x000003FF, shift 0, sample delay SLOT_CYCLES/2, minimum gap 2.
- R2: Every transition of the selected strobe pin, rising or falling, opens one slot, so a strobe toggling once per slot yields one event per valid slot.
- R3: With sample delay D greater than 0, a slot captures the bus as it stood D fast cycles after the strobe transition reached the input. Data that changes k cycles after the transition is captured when k <= D and is not captured when k > D.
- R4: A slot whose selected valid pin is low produces no event, whatever the codeword bits hold.
- R5: Valid slots in consecutive strobe periods, with no idle slot between them, each produce their own event, in order.
- R6: The register at address 0 (bits 4:0) selects the strobe pin, and the register at address 1 (bits 4:0) selects the valid pin. Both index into the 32-bit bus.
- R7: The event index is bits 9:0 of ((bus AND mask) >> shift). The mask is at address 2 (bits 31:0) and the shift at address 3 (bits 4:0). Field bits above index bit 9 after the shift are dropped.
- R8: evt_valid stays high with a stable evt_index while evt_ready is low. A new capture while an event is pending replaces it. The event clears in the cycle after it is accepted with evt_ready high.
- R9: err_spacing pulses for one cycle when a strobe transition comes fewer than MIN_GAP cycles after the previous one. MIN_GAP is the register at address 5 (bits 7:0). The first transition after reset never raises it.
- R10: With the sample delay (address 4, bits 7:0) set to 0, the bus is sampled in the same cycle the transition is detected, so data changed one cycle after the transition is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dio_in | input | 32 | Asynchronous general-purpose input bus carrying strobe, valid and codeword |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| evt_valid | output | 1 | Event present on evt_index |
| evt_ready | input | 1 | Consumer accepts the event |
| evt_index | output | 10 | Codeword index of the event |
| err_spacing | output | 1 | One-cycle pulse when strobe transitions are too close together |

## Verification
The hardest case to reach is a codeword that changes within a slot, exactly at the sampling point. The bench toggles the strobe and then changes the codeword after a chosen number of fast cycles. Because the strobe and the data pass through the same synchronizer, the capture boundary can be set to the cycle, and the bench tests it on both sides of the delay and with a delay of zero. Overwriting a pending event is reached by holding ready low across two valid slots. Spacing errors are forced by raising the minimum gap above the slot length that the driver uses.

// File: rtl/cwrx_pkg.sv
package cwrx_pkg;
  localparam int BUS_W = 32;
  localparam int SEL_W = $clog2(BUS_W);
  localparam int IDX_W = 10;
  localparam int CNT_W = 8;

  typedef enum logic [2:0] {
    REG_STROBE = 3'd0,
    REG_VALID  = 3'd1,
    REG_MASK   = 3'd2,
    REG_SHIFT  = 3'd3,
    REG_DELAY  = 3'd4,
    REG_GAP    = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic [SEL_W-1:0] strobe_sel;
    logic [SEL_W-1:0] valid_sel;
    logic [BUS_W-1:0] mask;
    logic [SEL_W-1:0] shift;
    logic [CNT_W-1:0] delay;
    logic [CNT_W-1:0] min_gap;
  } rx_cfg_t;
endpackage

// File: rtl/cwrx_cfg.sv
module cwrx_cfg
  import cwrx_pkg::*;
#(
  parameter int SLOT_CYCLES    = 8,
  parameter int DEF_MIN_GAP    = 2,
  parameter int DEF_STROBE_PIN = 31,
  parameter int DEF_VALID_PIN  = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output rx_cfg_t          cfg
);
  localparam logic [BUS_W-1:0] DEF_MASK = BUS_W'((1 << IDX_W) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.strobe_sel <= SEL_W'(DEF_STROBE_PIN);
      cfg.valid_sel  <= SEL_W'(DEF_VALID_PIN);
      cfg.mask       <= DEF_MASK;
      cfg.shift      <= '0;
      cfg.delay      <= CNT_W'(SLOT_CYCLES / 2);
      cfg.min_gap    <= CNT_W'(DEF_MIN_GAP);
    end else if (we) begin
      case (addr)
        REG_STROBE: cfg.strobe_sel <= wdata[SEL_W-1:0];
        REG_VALID:  cfg.valid_sel  <= wdata[SEL_W-1:0];
        REG_MASK:   cfg.mask       <= wdata;
        REG_SHIFT:  cfg.shift      <= wdata[SEL_W-1:0];
        REG_DELAY:  cfg.delay      <= wdata[CNT_W-1:0];
        REG_GAP:    cfg.min_gap    <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cwrx_sync.sv
module cwrx_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/cwrx_slot_timer.sv
module cwrx_slot_timer
  import cwrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus,
  input  rx_cfg_t          cfg,
  output logic             edge_det,
  output logic             capture,
  output logic             warm_done,
  output logic             err_spacing
);
  localparam int WARM_LAST = SYNC_STAGES + 1;
  localparam int WARM_W    = $clog2(WARM_LAST + 1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [WARM_W-1:0] warm_cnt;
  logic              strb_prev;
  logic              strb_cur;
  logic              armed;
  logic [CNT_W-1:0]  dly_cnt;
  logic              fire;
  logic              seen;
  logic [CNT_W-1:0]  gap_cnt;

  assign warm_done = (warm_cnt == WARM_W'(WARM_LAST));
  assign strb_cur  = bus[cfg.strobe_sel];
  assign edge_det  = warm_done && (strb_cur != strb_prev);

  // warm-up: hold off edge detection until the sync chain holds real data
  always_ff @(posedge clk) begin
    if (!rst_n)          warm_cnt <= '0;
    else if (!warm_done) warm_cnt <= warm_cnt + WARM_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) strb_prev <= 1'b0;
    else        strb_prev <= strb_cur;
  end

  // sampling-point timer
  assign fire    = (edge_det && (cfg.delay == '0)) || (armed && (dly_cnt == '0));
  assign capture = fire && bus[cfg.valid_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      dly_cnt <= '0;
    end else if (edge_det && (cfg.delay != '0)) begin
      armed   <= 1'b1;
      dly_cnt <= cfg.delay - CNT_ONE;
    end else if (armed) begin
      if (dly_cnt == '0) armed   <= 1'b0;
      else               dly_cnt <= dly_cnt - CNT_ONE;
    end
  end

  // strobe spacing monitor
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen        <= 1'b0;
      gap_cnt     <= CNT_MAX;
      err_spacing <= 1'b0;
    end else begin
      err_spacing <= edge_det && seen && (gap_cnt < cfg.min_gap);
      if (edge_det) begin
        seen    <= 1'b1;
        gap_cnt <= CNT_ONE;
      end else if (gap_cnt != CNT_MAX) begin
        gap_cnt <= gap_cnt + CNT_ONE;
      end
    end
  end
endmodule

// File: rtl/cwrx_extract.sv
module cwrx_extract
  import cwrx_pkg::*;
(
  input  logic [BUS_W-1:0] bus,
  input  logic [BUS_W-1:0] mask,
  input  logic [SEL_W-1:0] shift,
  output logic [IDX_W-1:0] index
);
  logic [BUS_W-1:0] field;

  always_comb begin
    field = (bus & mask) >> shift;
    index = field[IDX_W-1:0];
  end
endmodule

// File: rtl/cw_strobe_rx.sv
module cw_strobe_rx
  import cwrx_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int SLOT_CYCLES    = 8,
  parameter int DEF_MIN_GAP    = 2,
  parameter int DEF_STROBE_PIN = 31,
  parameter int DEF_VALID_PIN  = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] dio_in,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [BUS_W-1:0] cfg_wdata,
  output logic             evt_valid,
  input  logic             evt_ready,
  output logic [IDX_W-1:0] evt_index,
  output logic             err_spacing
);
  rx_cfg_t          cfg;
  logic [BUS_W-1:0] bus_s;
  logic             edge_det;
  logic             capture;
  logic             warm_done;
  logic [IDX_W-1:0] idx_now;

  cwrx_cfg #(
    .SLOT_CYCLES   (SLOT_CYCLES),
    .DEF_MIN_GAP   (DEF_MIN_GAP),
    .DEF_STROBE_PIN(DEF_STROBE_PIN),
    .DEF_VALID_PIN (DEF_VALID_PIN)
  ) u_cfg (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (cfg_we),
    .addr (cfg_addr),
    .wdata(cfg_wdata),
    .cfg  (cfg)
  );

  cwrx_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (dio_in),
    .dout (bus_s)
  );

  cwrx_slot_timer #(.SYNC_STAGES(SYNC_STAGES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus        (bus_s),
    .cfg        (cfg),
    .edge_det   (edge_det),
    .capture    (capture),
    .warm_done  (warm_done),
    .err_spacing(err_spacing)
  );

  cwrx_extract u_extract (
    .bus  (bus_s),
    .mask (cfg.mask),
    .shift(cfg.shift),
    .index(idx_now)
  );

  // single-entry output stage; a fresh capture replaces a pending event
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid <= 1'b0;
      evt_index <= '0;
    end else if (capture) begin
      evt_valid <= 1'b1;
      evt_index <= idx_now;
    end else if (evt_ready) begin
      evt_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cwrx_checker.sv
module cwrx_checker
  import cwrx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             evt_valid,
  input logic             evt_ready,
  input logic [IDX_W-1:0] evt_index,
  input logic             err_spacing,
  input logic             capture,
  input logic             edge_det,
  input logic             warm_done
);
  p_evt_after_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> evt_valid);

  p_hold_while_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready && !capture) |=> (evt_valid && $stable(evt_index)));

  p_clear_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready && !capture) |=> !evt_valid);

  p_rise_needs_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_valid) |-> $past(capture));

  p_err_needs_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_spacing |-> $past(edge_det));

  p_no_edge_in_warmup_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_done |-> !edge_det);
endmodule

bind cw_strobe_rx cwrx_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_valid  (evt_valid),
  .evt_ready  (evt_ready),
  .evt_index  (evt_index),
  .err_spacing(err_spacing),
  .capture    (capture),
  .edge_det   (edge_det),
  .warm_done  (warm_done)
);

// File: tb/tb_cw_strobe_rx.sv
`timescale 1ns/1ps
module tb_cw_strobe_rx;
  localparam int SLOT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dio_in = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        evt_valid;
  logic        evt_ready = 1'b1;
  logic [9:0]  evt_index;
  logic        err_spacing;

  int checks = 0;
  int failures = 0;
  int err_cnt = 0;
  bit finished = 0;
  logic [9:0] expq[$];

  // bench view of the configuration
  int          sp = 31, vp = 30;
  logic [31:0] mask_b = 32'h3FF;
  int          shift_b = 0;
  int          delay_b = SLOT / 2;
  logic        strobe_lvl = 1'b0;

  always #4 clk = ~clk;

  cw_strobe_rx dut (
    .clk(clk), .rst_n(rst_n), .dio_in(dio_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_index(evt_index),
    .err_spacing(err_spacing)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] compose(input logic [31:0] raw, input logic s, input logic v);
    logic [31:0] b;
    b = raw;
    b[sp] = s;
    b[vp] = v;
    return b;
  endfunction

  function automatic logic [9:0] expect_idx(input logic [31:0] b);
    logic [31:0] f;
    f = (b & mask_b) >> shift_b;
    return f[9:0];
  endfunction

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // driver: one slot, strobe toggled, pushes the expected index
  task automatic send_slot(input logic v, input logic [31:0] raw, input bit push, input int hold);
    logic [31:0] b;
    @(negedge clk);
    strobe_lvl = ~strobe_lvl;
    b = compose(raw, strobe_lvl, v);
    dio_in = b;
    if (push && v) expq.push_back(expect_idx(b));
    repeat (hold - 1) @(negedge clk);
  endtask

  // slot whose codeword changes k cycles after the strobe transition (R3, R10)
  task automatic send_split(input logic [31:0] ra, input logic [31:0] rb, input int k);
    logic [31:0] ba, bb;
    @(negedge clk);
    strobe_lvl = ~strobe_lvl;
    ba = compose(ra, strobe_lvl, 1'b1);
    bb = compose(rb, strobe_lvl, 1'b1);
    dio_in = ba;
    expq.push_back((k <= delay_b) ? expect_idx(bb) : expect_idx(ba));
    repeat (k) @(negedge clk);
    dio_in = bb;
    repeat (SLOT - 1 - k) @(negedge clk);
  endtask

  task automatic drain(input string req);
    repeat (SLOT + 8) @(negedge clk);
    chk(expq.size() == 0, req, expq.size(), 0);
  endtask

  // bring the bus to all zero with the strobe low, ready for a pin change
  task automatic park();
    if (strobe_lvl) send_slot(1'b0, 32'h0, 0, SLOT);
    @(negedge clk);
    dio_in = '0;
    repeat (4) @(negedge clk);
  endtask

  // monitor: scoreboard compare on each accepted event
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && evt_valid && evt_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R4 unexpected event", int'(evt_index), -1);
        end else begin
          logic [9:0] e;
          e = expq.pop_front();
          chk(evt_index == e, "R2/R7 event index", int'(evt_index), int'(e));
        end
      end
      if (rst_n && err_spacing) err_cnt++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(evt_valid == 1'b0, "R1 evt_valid in reset", int'(evt_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #2;
    chk(evt_valid == 1'b0, "R1 evt_valid after reset", int'(evt_valid), 0);
    chk(err_spacing == 1'b0, "R1 err after reset", int'(err_spacing), 0);

    // R2/R5: back-to-back valid slots on both strobe edges
    send_slot(1'b1, 32'h0000_0123, 1, SLOT);
    send_slot(1'b1, 32'h0000_02A5, 1, SLOT);
    send_slot(1'b1, 32'h0000_03FF, 1, SLOT);
    send_slot(1'b1, 32'h0000_0001, 1, SLOT);
    drain("R5 back-to-back drained");

    // R4: valid low, busy codeword bits ignored
    send_slot(1'b0, 32'h0000_03AA, 1, SLOT);
    send_slot(1'b0, 32'h0000_0155, 1, SLOT);
    send_slot(1'b1, 32'h0000_0077, 1, SLOT);
    drain("R4 only valid slot reported");
    chk(err_cnt == 0, "R9 no error at normal spacing", err_cnt, 0);

    // R7: mask and shift, then truncation to 10 bits
    cfg_write(3'd2, 32'h0000_FF00); mask_b = 32'h0000_FF00;
    cfg_write(3'd3, 32'd8);         shift_b = 8;
    send_slot(1'b1, 32'h0012_AB34, 1, SLOT);
    send_slot(1'b1, 32'h0000_5600, 1, SLOT);
    drain("R7 mask shift");
    cfg_write(3'd2, 32'h00FF_F000); mask_b = 32'h00FF_F000;
    cfg_write(3'd3, 32'd12);        shift_b = 12;
    send_slot(1'b1, 32'h00FF_F000, 1, SLOT);
    drain("R7 truncation");
    cfg_write(3'd2, 32'h0000_03FF); mask_b = 32'h3FF;
    cfg_write(3'd3, 32'd0);         shift_b = 0;

    // R6: move strobe and valid pins
    park();
    cfg_write(3'd0, 32'd5); sp = 5;
    cfg_write(3'd1, 32'd6); vp = 6;
    cfg_write(3'd2, 32'hFFFF_FF80); mask_b = 32'hFFFF_FF80;
    cfg_write(3'd3, 32'd7); shift_b = 7;
    send_slot(1'b1, 32'hC000_2A80, 1, SLOT);
    send_slot(1'b0, 32'h0001_0000, 1, SLOT);
    send_slot(1'b1, 32'h0000_1F00, 1, SLOT);
    drain("R6 pin selection");
    park();
    cfg_write(3'd0, 32'd31); sp = 31;
    cfg_write(3'd1, 32'd30); vp = 30;
    cfg_write(3'd2, 32'h0000_03FF); mask_b = 32'h3FF;
    cfg_write(3'd3, 32'd0); shift_b = 0;

    // R3: sampling point at the programmed delay
    send_split(32'h0AA, 32'h155, 4);
    send_split(32'h0AA, 32'h155, 5);
    drain("R3 sampling boundary");
    cfg_write(3'd4, 32'd2); delay_b = 2;
    send_split(32'h011, 32'h022, 2);
    send_split(32'h011, 32'h022, 3);
    drain("R3 short delay boundary");

    // R10: zero delay samples at the detection cycle
    cfg_write(3'd4, 32'd0); delay_b = 0;
    send_split(32'h101, 32'h202, 1);
    send_slot(1'b1, 32'h3C3, 1, SLOT);
    drain("R10 zero delay");
    cfg_write(3'd4, 32'd4); delay_b = 4;

    // R8: stall, hold, overwrite, accept
    @(negedge clk); evt_ready = 1'b0;
    send_slot(1'b1, 32'h0000_0111, 0, SLOT);
    repeat (6) @(negedge clk); #2;
    chk(evt_valid == 1'b1, "R8 pending held", int'(evt_valid), 1);
    chk(evt_index == 10'h111, "R8 pending index", int'(evt_index), 'h111);
    repeat (3) @(negedge clk); #2;
    chk(evt_index == 10'h111 && evt_valid, "R8 stable while stalled", int'(evt_index), 'h111);
    send_slot(1'b1, 32'h0000_0222, 0, SLOT);
    repeat (6) @(negedge clk); #2;
    chk(evt_index == 10'h222, "R8 overwrite by newer capture", int'(evt_index), 'h222);
    expq.push_back(10'h222);
    @(negedge clk); evt_ready = 1'b1;
    repeat (2) @(negedge clk); #2;
    chk(evt_valid == 1'b0, "R8 clears after accept", int'(evt_valid), 0);
    drain("R8 single delivery");

    // R9: spacing error
    cfg_write(3'd5, 32'd10);
    repeat (20) @(negedge clk);
    err_cnt = 0;
    send_slot(1'b0, 32'h0, 0, SLOT);
    send_slot(1'b0, 32'h0, 0, SLOT);
    send_slot(1'b0, 32'h0, 0, SLOT);
    repeat (6) @(negedge clk);
    chk(err_cnt == 2, "R9 close strobe edges flagged", err_cnt, 2);
    cfg_write(3'd5, 32'd2);
    err_cnt = 0;
    send_slot(1'b0, 32'h0, 0, SLOT);
    send_slot(1'b0, 32'h0, 0, SLOT);
    repeat (6) @(negedge clk);
    chk(err_cnt == 0, "R9 no flag at wide spacing", err_cnt, 0);

    drain("R2 final scoreboard empty");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule